// File: doc/BRIEF.md
# Configurable Peripheral Interrupt Controller

This block collects eight interrupt sources from one peripheral and presents them to software through a small register window. Each source is configured on its own. A sense-kind bit selects level or edge detection. Two independent polarity bits, one for high and one for low, pick the active level or edge. When both polarity bits are set on an edge source, it fires on both transitions.

Detected events are held in a latched status vector until software acknowledges them. Software acknowledges by writing a one-hot or multi-bit mask to an acknowledge register. Enables are changed only through separate set-mask and clear-mask registers, so changing one source never needs a read-modify-write of the others. Three status views can be read: the synchronized raw inputs, the latched events, and the pending bits (latched AND enabled). A single interrupt line goes high while any bit is pending.

The register bus is synchronous. It has an address offset, write data, a write strobe and combinational read data. The source inputs may be asynchronous and pass through a synchronizer before detection.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, the sense-kind, polarity-high, polarity-low, enable and latched vectors are all zero, and `irq_out` is low.
- R2: The sense-kind (offset 0x11), polarity-high (0x12) and polarity-low (0x13) registers read back exactly what was last written. The enable-set offset (0x15) reads the current enable vector. Offsets 0x14 and 0x16 and any unmapped offset such as 0x17 read as zero.
- R3: Offset 0x10 returns the source inputs after a two-flop synchronizer. An input change applied before clock edge k becomes visible after edge k+1, and not after edge k.
- R4: A write to 0x15 sets the enable bits where the data has a 1. A write to 0x16 clears the enable bits where the data has a 1. Zero bits leave enables unchanged, and writing 0xFF to 0x16 disables every source.
- R5: A source with sense-kind 0 is level sensitive. It latches on every cycle that its synchronized input is 1 with polarity-high set, or 0 with polarity-low set. It therefore re-latches right after an acknowledge while the level persists.
- R6: A source with sense-kind 1 is edge sensitive. With polarity-high it latches once on a 0-to-1 synchronized transition; with polarity-low it latches once on a 1-to-0 transition; with both bits set it latches on either. An acknowledged edge bit stays clear while the input is steady.
- R7: Latched status (offset 0x18) records events whether or not the source is enabled. Pending status (0x19) is latched AND enable, and `irq_out` is high exactly when any pending bit is 1.
- R8: A write to offset 0x14 clears the latched bits where the data has a 1. Latched bits are not cleared in any other way.
- R9: When a new event and an acknowledge of the same bit fall in the same cycle, the bit stays latched.
- R10: A source with both polarity bits 0 never latches, whatever its sense-kind and input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset for the current access |
| bus_wdata | input | 8 | Write data or bit mask |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| src_in | input | 8 | Raw interrupt source inputs, bit 0 is source 0 |
| irq_out | output | 1 | Aggregate interrupt, high while any pending bit is set |

## Verification
The bound checker watches four things on every cycle. Set-mask writes must turn their enables on, and clear-mask writes must turn them off. A latched bit must never drop in a cycle without an acknowledge write. The interrupt line must agree with the latched and enable vectors. The detection modes are shown only by the bench's scenarios: level, rising, falling, both-edge and mixed configurations, and the two-cycle synchronizer latency. The same applies to level re-latching after an acknowledge, the event-over-acknowledge collision, and the register read-back values.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // Register offsets; software decodes these, so they are fixed.
   localparam int unsigned OFS_RAW   = 'h10;
   localparam int unsigned OFS_KIND  = 'h11;
   localparam int unsigned OFS_POLHI = 'h12;
   localparam int unsigned OFS_POLLO = 'h13;
   localparam int unsigned OFS_ACK   = 'h14;
   localparam int unsigned OFS_ENSET = 'h15;
   localparam int unsigned OFS_ENCLR = 'h16;
   localparam int unsigned OFS_LATCH = 'h18;
   localparam int unsigned OFS_PEND  = 'h19;
   localparam int unsigned OFS_MAX   = 'h19;

   typedef enum logic [2:0] {
      RSEL_ZERO,
      RSEL_RAW,
      RSEL_KIND,
      RSEL_POLHI,
      RSEL_POLLO,
      RSEL_EN,
      RSEL_LATCH,
      RSEL_PEND
   } rsel_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= d_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_in;
               for (int s = 1; s < int'(STAGES); s++) begin
                  chain_q[s] <= chain_q[s-1];
               end
            end
         end
      end
   endgenerate

   assign d_out = chain_q[LAST];
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic edge_mode,
   input  logic pol_hi,
   input  logic pol_lo,
   output logic event_o
);
   logic prev_q;
   logic rise, fall, lvl_hit, edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      rise     = lvl & ~prev_q;
      fall     = ~lvl & prev_q;
      lvl_hit  = (pol_hi & lvl) | (pol_lo & ~lvl);
      edge_hit = (pol_hi & rise) | (pol_lo & fall);
      event_o  = edge_mode ? edge_hit : lvl_hit;
   end
endmodule

// File: rtl/pirq_cfg.sv
module pirq_cfg #(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [N_SRC-1:0]  kind_q,
   output logic [N_SRC-1:0]  polhi_q,
   output logic [N_SRC-1:0]  pollo_q,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  ack_mask
);
   import pirq_pkg::*;

   logic [N_SRC-1:0] wmask;
   assign wmask = bus_wdata[N_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= '0;
         polhi_q <= '0;
         pollo_q <= '0;
         en_q    <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            ADDR_W'(OFS_KIND):  kind_q  <= wmask;
            ADDR_W'(OFS_POLHI): polhi_q <= wmask;
            ADDR_W'(OFS_POLLO): pollo_q <= wmask;
            ADDR_W'(OFS_ENSET): en_q    <= en_q | wmask;
            ADDR_W'(OFS_ENCLR): en_q    <= en_q & ~wmask;
            default: ;
         endcase
      end
   end

   always_comb begin
      ack_mask = '0;
      if (bus_we && (bus_addr == ADDR_W'(OFS_ACK))) ack_mask = wmask;
   end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  src_in,
   output logic              irq_out
);
   import pirq_pkg::*;

   localparam int unsigned MIN_ADDR_W = $clog2(OFS_MAX + 1);

   generate
      if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_nsrc
         $error("pirq_ctrl: N_SRC must be in 1..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("pirq_ctrl: ADDR_W too narrow for the register offsets");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pirq_ctrl: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [N_SRC-1:0] lvl_s;
   logic [N_SRC-1:0] kind_v, polhi_v, pollo_v, en_q, ack_mask;
   logic [N_SRC-1:0] ev;
   logic [N_SRC-1:0] latch_q;
   logic [N_SRC-1:0] pend;
   rsel_e            rsel;

   pirq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (src_in),
      .d_out (lvl_s)
   );

   pirq_cfg #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .kind_q    (kind_v),
      .polhi_q   (polhi_v),
      .pollo_q   (pollo_v),
      .en_q      (en_q),
      .ack_mask  (ack_mask)
   );

   generate
      for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
         pirq_detect det_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl_s[i]),
            .edge_mode (kind_v[i]),
            .pol_hi    (polhi_v[i]),
            .pol_lo    (pollo_v[i]),
            .event_o   (ev[i])
         );
      end
   endgenerate

   // New events take precedence over an acknowledge of the same bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q & ~ack_mask) | ev;
   end

   assign pend    = latch_q & en_q;
   assign irq_out = |pend;

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_RAW):   rsel = RSEL_RAW;
         ADDR_W'(OFS_KIND):  rsel = RSEL_KIND;
         ADDR_W'(OFS_POLHI): rsel = RSEL_POLHI;
         ADDR_W'(OFS_POLLO): rsel = RSEL_POLLO;
         ADDR_W'(OFS_ENSET): rsel = RSEL_EN;
         ADDR_W'(OFS_LATCH): rsel = RSEL_LATCH;
         ADDR_W'(OFS_PEND):  rsel = RSEL_PEND;
         default:            rsel = RSEL_ZERO;
      endcase
   end

   always_comb begin
      case (rsel)
         RSEL_RAW:   bus_rdata = DATA_W'(lvl_s);
         RSEL_KIND:  bus_rdata = DATA_W'(kind_v);
         RSEL_POLHI: bus_rdata = DATA_W'(polhi_v);
         RSEL_POLLO: bus_rdata = DATA_W'(pollo_v);
         RSEL_EN:    bus_rdata = DATA_W'(en_q);
         RSEL_LATCH: bus_rdata = DATA_W'(latch_q);
         RSEL_PEND:  bus_rdata = DATA_W'(pend);
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              irq_out,
   input logic [N_SRC-1:0]  en_q,
   input logic [N_SRC-1:0]  latch_q
);
   import pirq_pkg::*;

   localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'({N_SRC{1'b1}});

   logic wr_set, wr_clr, wr_ack;
   assign wr_set = bus_we && (bus_addr == ADDR_W'(OFS_ENSET));
   assign wr_clr = bus_we && (bus_addr == ADDR_W'(OFS_ENCLR));
   assign wr_ack = bus_we && (bus_addr == ADDR_W'(OFS_ACK));

   a_r4_enset_turns_on: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((DATA_W'(en_q) & $past(bus_wdata) & SRC_MASK) == ($past(bus_wdata) & SRC_MASK)));

   a_r4_enclr_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((DATA_W'(en_q) & $past(bus_wdata)) == '0));

   a_r8_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ack |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

   a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((latch_q & en_q) != '0));

   a_r7_pending_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((latch_q & en_q) != '0) |-> irq_out);
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .irq_out   (irq_out),
   .en_q      (en_q),
   .latch_q   (latch_q)
);

// File: tb/pirq_ctrl_tb_top.sv
module pirq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr;
   logic [7:0] bus_wdata;
   logic       bus_we;
   logic [7:0] bus_rdata;
   logic [7:0] src_in;
   logic       irq_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   localparam logic [7:0] A_RAW = 8'h10, A_KIND = 8'h11, A_HI = 8'h12, A_LO = 8'h13,
                          A_ACK = 8'h14, A_ENS = 8'h15, A_ENC = 8'h16, A_GAP = 8'h17,
                          A_LAT = 8'h18, A_PND = 8'h19;

   // {kind, pol_hi, pol_lo, input_before, input_after, expected_latched}
   localparam int NVEC = 8;
   localparam logic [47:0] VEC [NVEC] = '{
      {8'hFF, 8'hFF, 8'h00, 8'h00, 8'hA5, 8'hA5},  // R6 rising
      {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'hC3},  // R6 falling
      {8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'hF0, 8'hFF},  // R6 both edges
      {8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 8'h81},  // R5 level high
      {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h7E, 8'h81},  // R5 level low
      {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00},  // R10 no polarity
      {8'hF0, 8'hCC, 8'hAA, 8'h00, 8'hFF, 8'hCE},  // R5/R6 mixed
      {8'h0F, 8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFA}   // R5/R6 mixed
   };

   pirq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .src_in    (src_in),
      .irq_out   (irq_out)
   );

   always #4 clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_KIND, v); chk("R1 kind", v, 8'h00);
      rd(A_HI, v);   chk("R1 polhi", v, 8'h00);
      rd(A_LO, v);   chk("R1 pollo", v, 8'h00);
      rd(A_ENS, v);  chk("R1 enable", v, 8'h00);
      rd(A_LAT, v);  chk("R1 latched", v, 8'h00);
      chk("R1 irq", {7'b0, irq_out}, 8'h00);

      // R2 read-back
      wr(A_KIND, 8'h5A); rd(A_KIND, v); chk("R2 kind", v, 8'h5A);
      wr(A_HI, 8'h33);   rd(A_HI, v);   chk("R2 polhi", v, 8'h33);
      wr(A_LO, 8'hC3);   rd(A_LO, v);   chk("R2 pollo", v, 8'hC3);
      rd(A_ACK, v); chk("R2 ack reads zero", v, 8'h00);
      rd(A_ENC, v); chk("R2 enclr reads zero", v, 8'h00);
      rd(A_GAP, v); chk("R2 unmapped reads zero", v, 8'h00);

      // R3 synchronizer latency
      src_in = 8'h96;
      idle(1); rd(A_RAW, v); chk("R3 raw after one edge", v, 8'h00);
      idle(1); rd(A_RAW, v); chk("R3 raw after two edges", v, 8'h96);

      // R4 enable set / clear masks
      wr(A_ENS, 8'h0F); rd(A_ENS, v); chk("R4 set 0F", v, 8'h0F);
      wr(A_ENS, 8'h30); rd(A_ENS, v); chk("R4 set 30", v, 8'h3F);
      wr(A_ENC, 8'h05); rd(A_ENC - 8'h1, v); chk("R4 clr 05", v, 8'h3A);
      wr(A_ENC, 8'hFF); rd(A_ENS, v); chk("R4 clr all", v, 8'h00);

      // Vector table: R5 R6 R10
      for (int i = 0; i < NVEC; i++) begin
         wr(A_KIND, VEC[i][47:40]);
         wr(A_HI,   VEC[i][39:32]);
         wr(A_LO,   VEC[i][31:24]);
         src_in = VEC[i][23:16];
         idle(4);
         wr(A_ACK, 8'hFF);
         src_in = VEC[i][15:8];
         idle(4);
         rd(A_LAT, v);
         chk($sformatf("R5/R6/R10 vector %0d", i), v, VEC[i][7:0]);
      end

      // R7 latch independent of enable; pending and irq
      rd(A_PND, v); chk("R7 pending with no enable", v, 8'h00);
      chk("R7 irq low with no enable", {7'b0, irq_out}, 8'h00);
      wr(A_ENS, 8'h02);
      rd(A_PND, v); chk("R7 pending", v, 8'h02);
      chk("R7 irq high", {7'b0, irq_out}, 8'h01);

      // R8 acknowledge clears only masked bits
      wr(A_ACK, 8'h02); idle(2);
      rd(A_LAT, v); chk("R8 ack one bit", v, 8'hF8);
      chk("R8 irq low after ack", {7'b0, irq_out}, 8'h00);

      // R5 level bits re-latch after ack while level persists
      wr(A_ACK, 8'hF0); idle(1);
      rd(A_LAT, v); chk("R5 relatch after ack", v, 8'hA8);

      // R9 event and ack in the same cycle
      wr(A_ENC, 8'hFF);
      wr(A_KIND, 8'hFF); wr(A_HI, 8'hFF); wr(A_LO, 8'h00);
      src_in = 8'h00;
      idle(4);
      wr(A_ACK, 8'hFF); idle(1);
      rd(A_LAT, v); chk("R6 steady edge stays clear", v, 8'h00);
      src_in = 8'h01;
      idle(2);
      wr(A_ACK, 8'h01);
      rd(A_LAT, v); chk("R9 event beats ack", v, 8'h01);
      wr(A_ACK, 8'h01); idle(2);
      rd(A_LAT, v); chk("R6 single latch per edge", v, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule